// File: doc/BRIEF.md
# I2C Serial Memory Slave Controller

This block is the serial-side engine of a 256-byte memory that answers on an I2C bus. It samples the raw SCL and SDA lines with the system clock and finds start and stop conditions. It collects the control byte and matches it against the three strapped address pins. It acknowledges in the ninth clock and runs the usual memory transfers: byte write, page write, current-address read, random read and sequential read. The SDA pin is driven as an open-drain pull-low enable. The memory array is an inferred RAM inside the block and has no reset.

Two control codes are decoded. Code 0b1010 reaches the array. Code 0b0110 reaches the write-protection registers, which belong to a separate policy unit. That unit sees the received byte and the word address. It answers with two levels: an acknowledge permit for protection-register traffic and a write permit for array data bytes. A protection-register write shows up as a single-cycle strobe.

One shared address counter serves both directions. It persists between transactions and always holds the address after the last byte touched. Reads advance it across the whole array, while writes advance it only inside the current 16-byte page.

Top module: `serial_mem_slave`

## Requirements
- R1: A start (SDA falling while SCL is high) begins control-byte reception from any state, aborting any transfer in progress without writing. A stop (SDA rising while SCL is high) returns the block to idle with SDA released. After reset SDA is released.
- R2: The control byte is taken MSB first. Bits 7:4 hold the code, bits 3:1 must equal `devAddr`, and bit 0 is the direction (1 = read). The block acknowledges code 0b1010, and code 0b0110 only while `protAck` is high. Any other byte gets no acknowledge, and the block then ignores the bus until the next start.
- R3: The acknowledge pulls SDA low from the SCL fall that ends the eighth bit until the SCL fall that ends the ninth.
- R4: In a write to the array, the byte after the control byte is the word address. It is always acknowledged and loads the address counter.
- R5: An array data byte received while `arrWrAllow` is high is acknowledged and stored at the counter. The counter then increments its low 4 bits only, so a page write wraps inside its 16-byte page.
- R6: An array data byte received while `arrWrAllow` is low is not acknowledged, and both the memory and the counter are left unchanged.
- R7: A read sends the byte at the counter MSB first and increments the counter across the full 8 bits (0xFF wraps to 0x00). A master acknowledge continues with the next byte. A master non-acknowledge ends the read with SDA released.
- R8: The counter keeps its value between transactions, so a current-address read returns the byte after the last byte accessed.
- R9: A dummy write carrying only the word address, then a repeated start and a read control byte, returns data from that address.
- R10: The sequence start, nine clocks with SDA high, start, stop leaves the block idle and ready for a normal transaction.
- R11: For code 0b0110, the word-address and data bytes are acknowledged only while `protAck` is high. An acknowledged data byte pulses `protWrStb` for exactly one cycle. A 0b0110 read returns 0xFF and leaves the address counter unchanged.
- R12: The block changes its SDA drive only while SCL is low, apart from releasing it on a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL level |
| sdaIn | input | 1 | Raw SDA level as seen on the wired bus |
| devAddr | input | 3 | Strapped device address pins |
| protAck | input | 1 | Policy permit to acknowledge protection-register traffic |
| arrWrAllow | input | 1 | Policy permit to write the array byte at `wordAddr` |
| sdaPullLow | output | 1 | Open-drain enable; 1 pulls SDA low |
| rxByte | output | 8 | Byte being received, complete at each acknowledge decision |
| wordAddr | output | 8 | Current value of the address counter |
| protWrStb | output | 1 | One-cycle pulse on an accepted protection-register write |

## Verification
The assertions rely on the master changing SDA only while SCL is low, except when it makes a start or a stop. They also rely on the master never making a start or stop while the block is pulling SDA low, and on each SCL level lasting several system clocks longer than the synchronizer delay. The bench master runs every bit as four equal phases of five clocks and sets SDA one phase after each SCL fall. It issues repeated starts only in phases where the block has released the line. Random transactions choose addresses, lengths, write permits and wrong device addresses. Directed cases cover page wrap, read wrap, an aborted write, bus recovery and the protection code.

// File: rtl/serial_mem_pkg.sv
package serial_mem_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CTL,
    S_CTL_ACK,
    S_ADDR,
    S_ADDR_ACK,
    S_WDATA,
    S_WDATA_ACK,
    S_RDATA,
    S_RDATA_ACK
  } slvState_t;

  // strobes from the protocol control to the datapath
  typedef struct packed {
    logic shiftIn;   // take one SDA bit into the receive shifter
    logic loadAddr;  // counter <= received word address
    logic writeMem;  // array[counter] <= received byte, page increment
    logic loadTx;    // tx <= array[counter], full increment
    logic loadOnes;  // tx <= all ones, counter untouched
    logic shiftTx;   // present the next transmit bit
  } dpCtl_t;

endpackage

// File: rtl/serial_mem_sync.sv
module serial_mem_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startSeen,
  output logic stopSeen
);
  logic [STAGES-1:0] sclPipe;
  logic [STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[STAGES-2:0], sclIn};
      sdaPipe <= {sdaPipe[STAGES-2:0], sdaIn};
      sclPrev <= sclPipe[STAGES-1];
      sdaPrev <= sdaPipe[STAGES-1];
    end
  end

  assign sclLvl    = sclPipe[STAGES-1];
  assign sdaLvl    = sdaPipe[STAGES-1];
  assign sclRise   = sclLvl & ~sclPrev;
  assign sclFall   = ~sclLvl & sclPrev;
  assign startSeen = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopSeen  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
endmodule

// File: rtl/serial_mem_ctrl.sv
module serial_mem_ctrl
  import serial_mem_pkg::*;
#(
  parameter logic [3:0] ARRAY_CODE = 4'hA,
  parameter logic [3:0] PROT_CODE  = 4'h6,
  parameter int         BYTE_BITS  = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclRise,
  input  logic                 sclFall,
  input  logic                 startSeen,
  input  logic                 stopSeen,
  input  logic                 sdaLvl,
  input  logic [BYTE_BITS-1:0] rxByte,
  input  logic [2:0]           devAddr,
  input  logic                 protAck,
  input  logic                 arrWrAllow,
  output dpCtl_t               dpCtl,
  output slvState_t            state,
  output logic                 ackDrive,
  output logic                 txOn,
  output logic                 protWrStb
);
  localparam int CNT_W = $clog2(BYTE_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

  logic [CNT_W-1:0] bitCnt, bitNx;
  slvState_t stateNx;
  logic ackNx, txOnNx, protSel, protNx, rdMode, rdNx, masterAck, mAckNx, strobeNx;
  logic [3:0] rxCode;
  logic ctlHit;

  assign rxCode = rxByte[BYTE_BITS-1 -: 4];
  assign ctlHit = (rxByte[3:1] == devAddr) &&
                  ((rxCode == ARRAY_CODE) || ((rxCode == PROT_CODE) && protAck));

  always_comb begin
    stateNx  = state;
    bitNx    = bitCnt;
    ackNx    = ackDrive;
    txOnNx   = txOn;
    protNx   = protSel;
    rdNx     = rdMode;
    mAckNx   = masterAck;
    strobeNx = 1'b0;
    dpCtl    = '0;
    if (startSeen) begin
      stateNx = S_CTL;
      bitNx   = '0;
      ackNx   = 1'b0;
      txOnNx  = 1'b0;
    end else if (stopSeen) begin
      stateNx = S_IDLE;
      ackNx   = 1'b0;
      txOnNx  = 1'b0;
    end else begin
      unique case (state)
        S_CTL, S_ADDR, S_WDATA: begin
          if (sclRise && bitCnt != LAST_BIT) begin
            dpCtl.shiftIn = 1'b1;
            bitNx = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == LAST_BIT) begin
            bitNx = '0;
            if (state == S_CTL) begin
              if (ctlHit) begin
                ackNx   = 1'b1;
                protNx  = (rxCode == PROT_CODE);
                rdNx    = rxByte[0];
                stateNx = S_CTL_ACK;
              end else begin
                stateNx = S_IDLE;
              end
            end else if (state == S_ADDR) begin
              if (!protSel || protAck) begin
                ackNx          = 1'b1;
                dpCtl.loadAddr = !protSel;
                stateNx        = S_ADDR_ACK;
              end else begin
                stateNx = S_IDLE;
              end
            end else begin
              if (protSel ? protAck : arrWrAllow) begin
                ackNx          = 1'b1;
                dpCtl.writeMem = !protSel;
                strobeNx       = protSel;
                stateNx        = S_WDATA_ACK;
              end else begin
                stateNx = S_IDLE;
              end
            end
          end
        end
        S_CTL_ACK, S_ADDR_ACK, S_WDATA_ACK: begin
          if (sclFall) begin
            ackNx = 1'b0;
            bitNx = '0;
            if (state == S_CTL_ACK && rdMode) begin
              stateNx        = S_RDATA;
              txOnNx         = 1'b1;
              dpCtl.loadOnes = protSel;
              dpCtl.loadTx   = !protSel;
            end else if (state == S_CTL_ACK) begin
              stateNx = S_ADDR;
            end else begin
              stateNx = S_WDATA;
            end
          end
        end
        S_RDATA: begin
          if (sclRise) begin
            bitNx = bitCnt + 1'b1;
          end else if (sclFall) begin
            if (bitCnt == LAST_BIT) begin
              txOnNx  = 1'b0;
              bitNx   = '0;
              stateNx = S_RDATA_ACK;
            end else begin
              dpCtl.shiftTx = 1'b1;
            end
          end
        end
        S_RDATA_ACK: begin
          if (sclRise) begin
            mAckNx = ~sdaLvl;
          end else if (sclFall) begin
            if (masterAck) begin
              stateNx        = S_RDATA;
              txOnNx         = 1'b1;
              dpCtl.loadOnes = protSel;
              dpCtl.loadTx   = !protSel;
            end else begin
              stateNx = S_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      bitCnt    <= '0;
      ackDrive  <= 1'b0;
      txOn      <= 1'b0;
      protSel   <= 1'b0;
      rdMode    <= 1'b0;
      masterAck <= 1'b0;
      protWrStb <= 1'b0;
    end else begin
      state     <= stateNx;
      bitCnt    <= bitNx;
      ackDrive  <= ackNx;
      txOn      <= txOnNx;
      protSel   <= protNx;
      rdMode    <= rdNx;
      masterAck <= mAckNx;
      protWrStb <= strobeNx;
    end
  end
endmodule

// File: rtl/serial_mem_dp.sv
module serial_mem_dp
  import serial_mem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PAGE_W    = 4,
  parameter int BYTE_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               dpCtl,
  input  logic                 sdaLvl,
  output logic [BYTE_BITS-1:0] rxByte,
  output logic                 txMsb,
  output logic [ADDR_W-1:0]    wordAddr
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_BITS-1:0] mem [DEPTH];
  logic [BYTE_BITS-1:0] shReg, txReg;
  logic [ADDR_W-1:0]    addrCnt, pageNext, seqNext;

  always_comb begin
    pageNext = addrCnt;
    pageNext[PAGE_W-1:0] = addrCnt[PAGE_W-1:0] + PAGE_W'(1);
  end
  assign seqNext = addrCnt + ADDR_W'(1);

  always_ff @(posedge clk) begin
    if (dpCtl.writeMem) mem[addrCnt] <= shReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg   <= '0;
      txReg   <= '1;
      addrCnt <= '0;
    end else begin
      if (dpCtl.shiftIn) shReg <= {shReg[BYTE_BITS-2:0], sdaLvl};
      if (dpCtl.loadAddr) begin
        addrCnt <= shReg[ADDR_W-1:0];
      end else if (dpCtl.writeMem) begin
        addrCnt <= pageNext;
      end else if (dpCtl.loadTx) begin
        txReg   <= mem[addrCnt];
        addrCnt <= seqNext;
      end
      if (dpCtl.loadOnes) txReg <= '1;
      else if (dpCtl.shiftTx) txReg <= {txReg[BYTE_BITS-2:0], 1'b1};
    end
  end

  assign rxByte   = shReg;
  assign txMsb    = txReg[BYTE_BITS-1];
  assign wordAddr = addrCnt;
endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
  import serial_mem_pkg::*;
#(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] ARRAY_CODE  = 4'hA,
  parameter logic [3:0] PROT_CODE   = 4'h6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic [2:0]        devAddr,
  input  logic              protAck,
  input  logic              arrWrAllow,
  output logic              sdaPullLow,
  output logic [7:0]        rxByte,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              protWrStb
);
  localparam int BYTE_BITS = 8;

  logic sclLvl, sdaLvl, sclRise, sclFall, startSeen, stopSeen;
  logic ackDrive, txOn, txMsb;
  dpCtl_t    dpCtl;
  slvState_t ctlState;

  serial_mem_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen)
  );

  serial_mem_ctrl #(
    .ARRAY_CODE(ARRAY_CODE), .PROT_CODE(PROT_CODE), .BYTE_BITS(BYTE_BITS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startSeen(startSeen), .stopSeen(stopSeen), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .devAddr(devAddr), .protAck(protAck), .arrWrAllow(arrWrAllow),
    .dpCtl(dpCtl), .state(ctlState), .ackDrive(ackDrive), .txOn(txOn),
    .protWrStb(protWrStb)
  );

  serial_mem_dp #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BYTE_BITS(BYTE_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtl(dpCtl), .sdaLvl(sdaLvl),
    .rxByte(rxByte), .txMsb(txMsb), .wordAddr(wordAddr)
  );

  assign sdaPullLow = ackDrive | (txOn & ~txMsb);
endmodule

// File: rtl/serial_mem_checker.sv
module serial_mem_checker
  import serial_mem_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter int         PAGE_W     = 4,
  parameter logic [3:0] ARRAY_CODE = 4'hA,
  parameter logic [3:0] PROT_CODE  = 4'h6
) (
  input logic              clk,
  input logic              rstN,
  input logic              sdaPullLow,
  input logic [2:0]        devAddr,
  input logic [7:0]        rxByte,
  input logic [ADDR_W-1:0] wordAddr,
  input logic              protWrStb,
  input logic              sclLvl,
  input logic              startSeen,
  input logic              stopSeen,
  input logic              ackDrive,
  input slvState_t         slvState,
  input logic              writeMem
);
  // control-byte acknowledge only on a pin match
  p_ack_pins_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && slvState == S_CTL_ACK) |-> rxByte[3:1] == devAddr);

  // control-byte acknowledge only for a known code
  p_ack_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(ackDrive) && slvState == S_CTL_ACK) |->
      (rxByte[7:4] == ARRAY_CODE || rxByte[7:4] == PROT_CODE));

  p_stop_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    stopSeen |=> !sdaPullLow);

  p_page_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    writeMem |=> (wordAddr[ADDR_W-1:PAGE_W] == $past(wordAddr[ADDR_W-1:PAGE_W]) &&
                  wordAddr[PAGE_W-1:0] == $past(wordAddr[PAGE_W-1:0]) + PAGE_W'(1)));

  p_strobe_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    protWrStb |=> !protWrStb);

  p_drive_scl_low_r12: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaPullLow) |-> (!sclLvl || $past(startSeen || stopSeen)));

  p_ack_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ackDrive) |-> !sclLvl || $past(startSeen || stopSeen));
endmodule

bind serial_mem_slave serial_mem_checker #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ARRAY_CODE(ARRAY_CODE), .PROT_CODE(PROT_CODE)
) u_chk (
  .clk(clk), .rstN(rstN), .sdaPullLow(sdaPullLow), .devAddr(devAddr),
  .rxByte(rxByte), .wordAddr(wordAddr), .protWrStb(protWrStb), .sclLvl(sclLvl),
  .startSeen(startSeen), .stopSeen(stopSeen), .ackDrive(ackDrive),
  .slvState(ctlState), .writeMem(dpCtl.writeMem)
);

// File: tb/serial_mem_slave_bench.sv
`timescale 1ns/1ps
module serial_mem_slave_bench;
  localparam int Q = 5;
  localparam int WATCHDOG = 195000;
  localparam logic [3:0] ARR = 4'hA;
  localparam logic [3:0] PROT = 4'h6;
  localparam logic [2:0] DEV = 3'b101;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic protAck = 1'b0;
  logic arrWrAllow = 1'b1;
  logic sdaPullLow, protWrStb;
  logic [7:0] rxByte, wordAddr;
  wire sdaBus = sdaM & ~sdaPullLow;

  always #10 clk = ~clk;

  serial_mem_slave u_serial_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .devAddr(DEV),
    .protAck(protAck), .arrWrAllow(arrWrAllow), .sdaPullLow(sdaPullLow),
    .rxByte(rxByte), .wordAddr(wordAddr), .protWrStb(protWrStb)
  );

  int nChecks = 0;
  int nFail = 0;
  int protCnt = 0;
  int r12Bad = 0;
  bit done = 0;
  logic prevPull = 1'b0;
  logic [7:0] refMem [256];
  logic [7:0] refAddr = 8'h00;

  always @(posedge clk) if (rstN && protWrStb) protCnt++;

  // R12 monitor: drive may change only while SCL is low
  always @(negedge clk) begin
    if (rstN && sdaPullLow !== prevPull && sclM) r12Bad++;
    prevPull = sdaPullLow;
  end

  function automatic logic [7:0] pageInc(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b0; waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ(); sclM = 1'b1; waitQ(); sdaM = 1'b1; waitQ();
  endtask

  task automatic sendBits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sdaM = b[i]; waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    end
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    sendBits(b, 8);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();
    acked = !sdaBus;
    waitQ(); sclM = 1'b0; waitQ();
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      waitQ(); sclM = 1'b1; waitQ(); b[i] = sdaBus; waitQ(); sclM = 1'b0; waitQ();
    end
    sdaM = mack ? 1'b0 : 1'b1;
    waitQ(); sclM = 1'b1; waitQ(); waitQ(); sclM = 1'b0; waitQ();
    sdaM = 1'b1;
  endtask

  task automatic readSeq(input int n, input string req);
    logic [7:0] b;
    for (int k = 0; k < n; k++) begin
      recvByte(k != n - 1, b);
      check(b === refMem[refAddr], req, b, refMem[refAddr]);
      refAddr = refAddr + 8'd1;
    end
  endtask

  task automatic writeTxn(input logic [7:0] a, input int n, input bit allow);
    bit ak;
    logic [7:0] d;
    busStart();
    sendByte({ARR, DEV, 1'b0}, ak); check(ak, "R2 write control ack", ak, 1);
    sendByte(a, ak); check(ak, "R4 word address ack", ak, 1);
    refAddr = a;
    arrWrAllow = allow;
    for (int k = 0; k < n; k++) begin
      d = 8'($urandom);
      sendByte(d, ak);
      if (allow) begin
        check(ak, "R5 data ack", ak, 1);
        refMem[refAddr] = d;
        refAddr = pageInc(refAddr);
      end else begin
        check(!ak, "R6 denied data nack", ak, 0);
        break;
      end
    end
    busStop();
    arrWrAllow = 1'b1;
  endtask

  task automatic readCur(input int n);
    bit ak;
    busStart();
    sendByte({ARR, DEV, 1'b1}, ak); check(ak, "R8 read control ack", ak, 1);
    readSeq(n, "R8 current address data");
    busStop();
  endtask

  task automatic randRead(input logic [7:0] a, input int n, input string req);
    bit ak;
    busStart();
    sendByte({ARR, DEV, 1'b0}, ak); check(ak, "R9 dummy write ack", ak, 1);
    sendByte(a, ak); check(ak, "R4 address ack", ak, 1);
    refAddr = a;
    busStart();
    sendByte({ARR, DEV, 1'b1}, ak); check(ak, "R9 repeated start read ack", ak, 1);
    readSeq(n, req);
    busStop();
  endtask

  task automatic finishRun();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    bit ak;
    logic [7:0] b;
    int c0;
    int unused;
    unused = $urandom(32'd4711);
    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0, "R1 reset releases SDA", sdaPullLow, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    check(sdaPullLow == 1'b0 && protWrStb == 1'b0, "R1 idle after reset", sdaPullLow, 0);

    for (int p = 0; p < 16; p++) writeTxn(8'(p * 16), 16, 1'b1);

    // page wrap: 0x3C..0x3F then 0x30, 0x31
    writeTxn(8'h3C, 6, 1'b1);
    check(refAddr == 8'h32, "R5 page wrap counter", refAddr, 8'h32);
    randRead(8'h30, 16, "R5 page wrap readback");
    // sequential read across the top of the array
    randRead(8'hFE, 4, "R7 sequential wrap");
    readCur(2);
    // denied write: memory and counter unchanged
    writeTxn(8'h50, 3, 1'b0);
    readCur(1);
    randRead(8'h50, 2, "R6 memory unchanged");

    // wrong pins and wrong code
    busStart();
    sendByte({ARR, DEV ^ 3'b001, 1'b1}, ak); check(!ak, "R2 pin mismatch nack", ak, 0);
    busStop();
    check(sdaPullLow == 1'b0, "R1 stop releases", sdaPullLow, 0);
    busStart();
    sendByte({4'hB, DEV, 1'b0}, ak); check(!ak, "R2 unknown code nack", ak, 0);
    busStop();
    readCur(1);

    // start in the middle of a data byte aborts the write (R1)
    busStart();
    sendByte({ARR, DEV, 1'b0}, ak); check(ak, "R1 control ack", ak, 1);
    sendByte(8'h70, ak); check(ak, "R1 address ack", ak, 1);
    refAddr = 8'h70;
    sendBits(~refMem[8'h70], 4);
    busStart();
    sendByte({ARR, DEV, 1'b1}, ak); check(ak, "R1 read after abort ack", ak, 1);
    readSeq(1, "R1 aborted write left memory");
    busStop();

    // recovery sequence (R10)
    busStart();
    sendByte({ARR, DEV, 1'b0}, ak); check(ak, "R10 control ack", ak, 1);
    sendBits(8'h00, 3);
    busStart();
    sendByte(8'hFF, ak); check(!ak, "R10 dummy clocks not acked", ak, 0);
    busStart();
    busStop();
    check(sdaPullLow == 1'b0, "R10 idle after recovery", sdaPullLow, 0);
    readCur(2);

    // protection code (R11)
    busStart();
    sendByte({PROT, DEV, 1'b0}, ak); check(!ak, "R11 prot code without permit", ak, 0);
    busStop();
    protAck = 1'b1;
    busStart();
    sendByte({PROT, DEV, 1'b0}, ak); check(ak, "R11 prot control ack", ak, 1);
    sendByte(8'h00, ak); check(ak, "R11 prot address ack", ak, 1);
    c0 = protCnt;
    sendByte(8'h00, ak); check(ak, "R11 prot data ack", ak, 1);
    busStop();
    check(protCnt == c0 + 1, "R11 one strobe per write", protCnt - c0, 1);
    busStart();
    sendByte({PROT, DEV, 1'b1}, ak); check(ak, "R11 prot read ack", ak, 1);
    recvByte(1'b0, b); check(b == 8'hFF, "R11 prot read ones", b, 8'hFF);
    busStop();
    protAck = 1'b0;
    readCur(1);

    // constrained random mix
    for (int t = 0; t < 40; t++) begin
      int op;
      op = int'($urandom % 4);
      case (op)
        0: writeTxn(8'($urandom), 1 + int'($urandom % 18), ($urandom % 4) != 0);
        1: randRead(8'($urandom), 1 + int'($urandom % 12), "R7 random sequential read");
        2: readCur(1 + int'($urandom % 5));
        default: begin
          busStart();
          sendByte({ARR, DEV ^ 3'(1 + $urandom % 7), 1'b1}, ak);
          check(!ak, "R2 random pin mismatch", ak, 0);
          busStop();
        end
      endcase
    end

    check(r12Bad == 0, "R12 drive changes only with SCL low", r12Bad, 0);
    check(sdaPullLow == 1'b0, "R3 released after last transfer", sdaPullLow, 0);
    finishRun();
  end
endmodule